// File: doc/BRIEF.md
# Quad-Enable Setup Sequencer

This block is a host-side controller that moves a serial NOR flash out of its delivered single-lane configuration and into quad-capable operation. It does this by setting the non-volatile quad-enable bit of the flash status register. One pulse on `start_i` runs a fixed conversation with the flash over single-lane SPI (mode 0, MSB first). First it reads the status, and it stops early if quad-enable is already set. Otherwise it sends write-enable and confirms that the write-enable latch took. It then writes the status byte, keeping the upper non-volatile bits it read at the start. Next it polls until the internal write finishes, and a last status read verifies the outcome. The result is given as a `done_o` or `error_o` level.

A byte-wide SPI shifter inside the block generates the serial clock from the system clock. Chip select is dropped around each command and raised between commands for a programmable number of system clocks. A poll budget and a write-enable retry budget keep a flash that does not respond from hanging the sequence.

Top module: `qe_setup_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, `spi_cs_n_o` is 1, `spi_sck_o` is 0, and `done_o` and `error_o` are 0.
- R2: Each byte is sent in SPI mode 0, most significant bit first. `spi_mosi_o` is stable while `spi_sck_o` is high, `spi_miso_i` is sampled on the rising clock edge, and `spi_sck_o` stays low whenever `spi_cs_n_o` is high.
- R3: Between two commands, `spi_cs_n_o` stays high for at least `GAP_CYCLES` system clocks. `GAP_CYCLES` must be at least 2.
- R4: The first command after a start is a status read: opcode 05h, then one byte clocked in. If bit 6 (quad-enable) of that byte is 1, no write-enable and no status write are issued, and the sequence goes straight to the final check of R8.
- R5: A write-enable command is the single byte 06h, and it is followed by a status read. If bit 1 (write-enable latch) of that read is 0, write-enable is sent again. After `WREN_TRIES` write-enables that all read back 0, `error_o` is raised.
- R6: The status write is opcode 01h followed by one data byte. That byte equals the status read in R4, with bits 1:0 cleared and bit 6 set.
- R7: After the status write, status reads repeat while bit 1 or bit 0 (write in progress) of the returned byte is 1. If `POLL_LIMIT` consecutive reads return busy, `error_o` is raised and no further command is sent.
- R8: A final status read follows. `done_o` is raised if bit 6 is 1 and bit 1 is 0 in that read; otherwise `error_o` is raised.
- R9: `done_o` and `error_o` are never high together. Chip select stays high while either is high. Both hold until the next start. A start pulse received while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a setup sequence when idle or finished |
| done_o | output | 1 | Quad-enable confirmed; held until next start |
| error_o | output | 1 | Sequence gave up or verification failed; held until next start |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | SPI serial clock, idle low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
A wrong step register shows up at the pins within one command. It produces a wrong opcode byte or a missing byte on `spi_mosi_o`, and a flash model that decodes every transaction catches it at the next rise of chip select. A corrupted counter for polls, retries or the chip-select gap changes the number of transactions or the high time of chip select. That appears either at the next falling edge of chip select or as a wrong transaction count when the sequence finishes. A lost copy of the first status byte appears only in the data byte of the status write, so the checks on that byte use a starting status with bit 7 and the protect bits set.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;

    localparam int QE_POS  = 6;
    localparam int WEL_POS = 1;
    localparam int WIP_POS = 0;

    localparam logic [7:0] QE_SET_MASK = 8'h40;
    localparam logic [7:0] KEEP_MASK   = 8'hFC;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_OP,
        PH_OPW,
        PH_DAT,
        PH_DATW,
        PH_DONE,
        PH_FAIL
    } phase_e;

    typedef enum logic [2:0] {
        SP_PEEK,
        SP_WREN,
        SP_WELCHK,
        SP_WRITE,
        SP_POLL,
        SP_VERIFY
    } step_e;

    function automatic logic [7:0] step_opcode(step_e s);
        case (s)
            SP_WREN:  return OP_WREN;
            SP_WRITE: return OP_WRSR;
            default:  return OP_RDSR;
        endcase
    endfunction

    function automatic logic step_two_bytes(step_e s);
        return (s != SP_WREN);
    endfunction

endpackage

// File: rtl/qe_spi_byte.sv
module qe_spi_byte #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [2:0]       bitn;
        logic [DIV_W-1:0] div;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (go_i) begin
                r_d.active = 1'b1;
                r_d.sh     = tx_i;
                r_d.div    = '0;
                r_d.bitn   = '0;
                r_d.sck    = 1'b0;
            end
        end else if (r_q.div == DIV_LAST) begin
            r_d.div = '0;
            if (!r_q.sck) begin
                r_d.sck = 1'b1;
                r_d.rx  = {r_q.rx[6:0], miso_i};
            end else begin
                r_d.sck = 1'b0;
                if (r_q.bitn == 3'd7) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.bitn = r_q.bitn + 3'd1;
                    r_d.sh   = {r_q.sh[6:0], 1'b0};
                end
            end
        end else begin
            r_d.div = r_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sck_o  = r_q.sck;
    assign mosi_o = r_q.sh[7];
    assign done_o = r_q.done;
    assign rx_o   = r_q.rx;

endmodule

// File: rtl/qe_seq_ctrl.sv
module qe_seq_ctrl
    import qe_pkg::*;
#(
    parameter int GAP_CYCLES = 3,
    parameter int POLL_LIMIT = 16,
    parameter int WREN_TRIES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       xfer_done_i,
    input  logic [7:0] xfer_rx_i,
    output logic       xfer_go_o,
    output logic [7:0] xfer_tx_o,
    output logic       cs_n_o,
    output logic       done_o,
    output logic       error_o
);

    localparam int GAP_W  = $clog2(GAP_CYCLES + 1);
    localparam int POLL_W = $clog2(POLL_LIMIT + 1);
    localparam int TRY_W  = $clog2(WREN_TRIES + 1);

    localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(GAP_CYCLES - 1);
    localparam logic [POLL_W-1:0] POLL_MAX  = POLL_W'(POLL_LIMIT);
    localparam logic [TRY_W-1:0]  TRY_MAX   = TRY_W'(WREN_TRIES);

    typedef struct packed {
        phase_e            phase;
        step_e             step;
        logic [GAP_W-1:0]  gap;
        logic [POLL_W-1:0] polls;
        logic [TRY_W-1:0]  tries;
        logic [7:0]        first_sr;
        logic              cs_n;
        logic              done;
        logic              fail;
    } seq_t;

    seq_t s_q, s_d;
    logic fin;
    logic [POLL_W-1:0] polls_inc;

    assign polls_inc = s_q.polls + 1'b1;

    always_comb begin
        s_d       = s_q;
        xfer_go_o = 1'b0;
        xfer_tx_o = step_opcode(s_q.step);
        fin       = 1'b0;

        case (s_q.phase)
            PH_IDLE, PH_DONE, PH_FAIL: begin
                if (start_i) begin
                    s_d.phase = PH_GAP;
                    s_d.step  = SP_PEEK;
                    s_d.gap   = '0;
                    s_d.polls = '0;
                    s_d.tries = '0;
                    s_d.done  = 1'b0;
                    s_d.fail  = 1'b0;
                    s_d.cs_n  = 1'b1;
                end
            end
            PH_GAP: begin
                if (s_q.gap == GAP_LAST) begin
                    s_d.phase = PH_OP;
                    s_d.cs_n  = 1'b0;
                end else begin
                    s_d.gap = s_q.gap + 1'b1;
                end
            end
            PH_OP: begin
                xfer_go_o = 1'b1;
                s_d.phase = PH_OPW;
            end
            PH_OPW: begin
                if (xfer_done_i) begin
                    if (step_two_bytes(s_q.step)) begin
                        s_d.phase = PH_DAT;
                    end else begin
                        fin = 1'b1;
                    end
                end
            end
            PH_DAT: begin
                xfer_go_o = 1'b1;
                xfer_tx_o = (s_q.step == SP_WRITE) ?
                            ((s_q.first_sr & KEEP_MASK) | QE_SET_MASK) : 8'h00;
                s_d.phase = PH_DATW;
            end
            PH_DATW: begin
                if (xfer_done_i) begin
                    fin = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase

        if (fin) begin
            s_d.cs_n  = 1'b1;
            s_d.gap   = '0;
            s_d.phase = PH_GAP;
            case (s_q.step)
                SP_PEEK: begin
                    s_d.first_sr = xfer_rx_i;
                    s_d.step     = xfer_rx_i[QE_POS] ? SP_VERIFY : SP_WREN;
                end
                SP_WREN: begin
                    s_d.step  = SP_WELCHK;
                    s_d.tries = s_q.tries + 1'b1;
                end
                SP_WELCHK: begin
                    if (xfer_rx_i[WEL_POS]) begin
                        s_d.step = SP_WRITE;
                    end else if (s_q.tries == TRY_MAX) begin
                        s_d.phase = PH_FAIL;
                        s_d.fail  = 1'b1;
                    end else begin
                        s_d.step = SP_WREN;
                    end
                end
                SP_WRITE: begin
                    s_d.step  = SP_POLL;
                    s_d.polls = '0;
                end
                SP_POLL: begin
                    if (xfer_rx_i[WEL_POS] || xfer_rx_i[WIP_POS]) begin
                        s_d.polls = polls_inc;
                        if (polls_inc == POLL_MAX) begin
                            s_d.phase = PH_FAIL;
                            s_d.fail  = 1'b1;
                        end
                    end else begin
                        s_d.step = SP_VERIFY;
                    end
                end
                SP_VERIFY: begin
                    if (xfer_rx_i[QE_POS] && !xfer_rx_i[WEL_POS]) begin
                        s_d.phase = PH_DONE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_FAIL;
                        s_d.fail  = 1'b1;
                    end
                end
                default: s_d.phase = PH_FAIL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_n_o  = s_q.cs_n;
    assign done_o  = s_q.done;
    assign error_o = s_q.fail;

endmodule

// File: rtl/qe_setup_seq.sv
module qe_setup_seq #(
    parameter int SCK_HALF_DIV = 2,
    parameter int GAP_CYCLES   = 3,
    parameter int POLL_LIMIT   = 16,
    parameter int WREN_TRIES   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o,
    output logic error_o,
    output logic spi_cs_n_o,
    output logic spi_sck_o,
    output logic spi_mosi_o,
    input  logic spi_miso_i
);

    logic       xfer_go;
    logic [7:0] xfer_tx;
    logic       xfer_done;
    logic [7:0] xfer_rx;

    qe_seq_ctrl #(
        .GAP_CYCLES (GAP_CYCLES),
        .POLL_LIMIT (POLL_LIMIT),
        .WREN_TRIES (WREN_TRIES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .xfer_done_i (xfer_done),
        .xfer_rx_i   (xfer_rx),
        .xfer_go_o   (xfer_go),
        .xfer_tx_o   (xfer_tx),
        .cs_n_o      (spi_cs_n_o),
        .done_o      (done_o),
        .error_o     (error_o)
    );

    qe_spi_byte #(
        .HALF_DIV (SCK_HALF_DIV)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (xfer_go),
        .tx_i   (xfer_tx),
        .miso_i (spi_miso_i),
        .sck_o  (spi_sck_o),
        .mosi_o (spi_mosi_o),
        .done_o (xfer_done),
        .rx_o   (xfer_rx)
    );

endmodule

// File: rtl/qe_setup_seq_chk.sv
module qe_setup_seq_chk #(
    parameter int GAP_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic done_o,
    input logic error_o,
    input logic spi_cs_n_o,
    input logic spi_sck_o,
    input logic spi_mosi_o
);

    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 16'hFFFF;
        end else if (spi_cs_n_o) begin
            hi_cnt <= (hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1;
        end else begin
            hi_cnt <= 16'd0;
        end
    end

    initial begin
        assert_gap_param_R3: assert (GAP_CYCLES >= 2);
    end

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n_o |-> !spi_sck_o);

    assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n_o && spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o));

    assert_cs_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n_o) |-> (hi_cnt >= 16'(GAP_CYCLES)));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> spi_cs_n_o);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);

endmodule

bind qe_setup_seq qe_setup_seq_chk #(
    .GAP_CYCLES (GAP_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .done_o     (done_o),
    .error_o    (error_o),
    .spi_cs_n_o (spi_cs_n_o),
    .spi_sck_o  (spi_sck_o),
    .spi_mosi_o (spi_mosi_o)
);

// File: tb/qe_setup_seq_tb.sv
`timescale 1ns/1ps
module qe_setup_seq_tb;

    localparam int HALF  = 2;
    localparam int GAP   = 3;
    localparam int PLIM  = 8;
    localparam int TRIES = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic start;
    logic done, err, cs_n, sck, mosi;
    logic miso = 1'b0;

    always #10 clk = ~clk;

    qe_setup_seq #(
        .SCK_HALF_DIV (HALF),
        .GAP_CYCLES   (GAP),
        .POLL_LIMIT   (PLIM),
        .WREN_TRIES   (TRIES)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .done_o     (done),
        .error_o    (err),
        .spi_cs_n_o (cs_n),
        .spi_sck_o  (sck),
        .spi_mosi_o (mosi),
        .spi_miso_i (miso)
    );

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // flash configuration, written by the stimulus only
    logic [7:0] cfg_init;
    int         cfg_ign;
    bit         cfg_lock;
    int         cfg_busy;
    int         load_req = 0;

    // transaction log, written by the flash model only
    int q_op[$];
    int q_len[$];
    int q_dat[$];
    int q_ret[$];

    // behavioural flash
    int         load_seen = 0;
    logic [7:0] f_sr = 8'h00;
    bit         f_wel = 0;
    bit         f_pend = 0;
    int         f_until = 0;
    int         f_wren_left = 0;
    int         bitc = 0;
    logic [15:0] shin = 16'h0;
    logic [7:0] op_r = 8'hFF;
    logic [7:0] snap = 8'h00;
    logic       cs_prev = 1'b1;
    logic       sck_prev = 1'b0;

    always @(cs_n or sck or load_req) begin : flash_model
        logic [7:0] nv;
        if (load_req != load_seen) begin
            load_seen   = load_req;
            f_sr        = cfg_init;
            f_wel       = 0;
            f_pend      = 0;
            f_wren_left = cfg_ign;
            q_op.delete();
            q_len.delete();
            q_dat.delete();
            q_ret.delete();
        end
        if (f_pend && cyc >= f_until) begin
            f_pend = 0;
            f_wel  = 0;
        end
        if (cs_n !== cs_prev) begin
            if (cs_n === 1'b0) begin
                bitc = 0;
                shin = 16'h0;
                op_r = 8'hFF;
            end else if (cs_prev === 1'b0) begin
                q_op.push_back(int'(op_r));
                q_len.push_back(bitc);
                q_dat.push_back(int'(shin[7:0]));
                q_ret.push_back(int'(snap));
                if (op_r == 8'h06 && bitc == 8) begin
                    if (f_wren_left > 0) f_wren_left--;
                    else f_wel = 1;
                end
                if (op_r == 8'h01 && bitc == 16 && f_wel && !f_pend) begin
                    nv = shin[7:0];
                    if (cfg_lock) nv[6] = 1'b0;
                    f_sr[7:2] = nv[7:2];
                    f_pend    = 1;
                    f_until   = cyc + cfg_busy;
                end
            end
            cs_prev = cs_n;
        end
        if (sck !== sck_prev) begin
            if (cs_n === 1'b0) begin
                if (sck === 1'b1) begin
                    shin = {shin[14:0], mosi};
                    bitc++;
                    if (bitc == 8) begin
                        op_r = shin[7:0];
                        snap = {f_sr[7:2], f_wel, f_pend};
                    end
                end else if (bitc >= 8 && op_r == 8'h05) begin
                    miso = snap[7 - ((bitc - 8) % 8)];
                end
            end
            sck_prev = sck;
        end
    end

    // per-clock protocol monitor (R2, R3, R9)
    int   hi_n = 1000;
    logic m_sck_prev = 1'b0;
    logic m_mosi_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            mon_checks++;
            if (cs_n && sck) begin
                mon_fails++;
                $display("FAIL R2 sck high with cs high actual=%0d expected=0", sck);
            end
            mon_checks++;
            if (!cs_n && sck && m_sck_prev && mosi !== m_mosi_prev) begin
                mon_fails++;
                $display("FAIL R2 mosi moved while sck high actual=%0d expected=%0d", mosi, m_mosi_prev);
            end
            mon_checks++;
            if (done && err) begin
                mon_fails++;
                $display("FAIL R9 done and error both high actual=1 expected=0");
            end
            if (cs_n) begin
                hi_n++;
            end else begin
                if (hi_n > 0) begin
                    mon_checks++;
                    if (hi_n < GAP) begin
                        mon_fails++;
                        $display("FAIL R3 chip select gap actual=%0d expected>=%0d", hi_n, GAP);
                    end
                end
                hi_n = 0;
            end
        end
        m_sck_prev  = sck;
        m_mosi_prev = mosi;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [7:0] init, input int ign, input bit lock,
                            input int busy, input bit poke);
        bit ended;
        cfg_init = init;
        cfg_ign  = ign;
        cfg_lock = lock;
        cfg_busy = busy;
        load_req++;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ended = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (i == 40 && poke) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (done || err) begin
                ended = 1;
                break;
            end
        end
        chk(ended, "R9 sequence did not finish", 0, 1);
    endtask

    int n;
    int wrens;
    int writes;

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        chk(sck == 1'b0, "R1 sck in reset", sck, 0);
        chk(done == 1'b0 && err == 1'b0, "R1 done/error in reset", {done, err}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(cs_n == 1'b1 && !done && !err, "R1 idle after reset", {cs_n, done, err}, 3'b100);

        // Case A: normal setup, preserved bits, extra start ignored
        run_case(8'hBC, 0, 0, 250, 1);
        n = q_op.size();
        chk(done == 1'b1 && err == 1'b0, "R8 normal run outcome", {done, err}, 2'b10);
        chk(n >= 7, "R7 normal run transaction count", n, 7);
        if (n >= 7) begin
            chk(q_op[0] == 5 && q_len[0] == 16, "R4 first command is status read", q_op[0], 5);
            chk(q_op[1] == 6 && q_len[1] == 8, "R5 write-enable single byte", q_op[1], 6);
            chk(q_op[2] == 5 && q_ret[2][1] == 1'b1, "R5 latch read after write-enable", q_ret[2], 2);
            chk(q_op[3] == 1 && q_len[3] == 16, "R6 status write opcode", q_op[3], 1);
            chk(q_dat[3] == 'hFC, "R6 status write data keeps bits", q_dat[3], 'hFC);
            for (int i = 4; i < n - 2; i++) begin
                chk(q_op[i] == 5 && (q_ret[i] & 3) != 0, "R7 busy poll repeats", q_ret[i], 3);
            end
            chk(q_op[n-2] == 5 && (q_ret[n-2] & 3) == 0, "R7 poll ends when idle", q_ret[n-2], 'hFC);
            chk(q_op[n-1] == 5 && q_ret[n-1] == 'hFC, "R8 final verify read", q_ret[n-1], 'hFC);
        end
        wrens = 0;
        foreach (q_op[i]) if (q_op[i] == 6) wrens++;
        chk(wrens == 1, "R9 start ignored while running", wrens, 1);
        repeat (30) @(negedge clk);
        chk(done == 1'b1 && cs_n == 1'b1, "R9 done held until next start", {done, cs_n}, 2'b11);

        // Case B: quad-enable already set
        run_case(8'h40, 0, 0, 100, 0);
        n = q_op.size();
        chk(done == 1'b1 && err == 1'b0, "R4 skip path outcome", {done, err}, 2'b10);
        chk(n == 2, "R4 skip path has two reads only", n, 2);
        writes = 0;
        foreach (q_op[i]) if (q_op[i] != 5) writes++;
        chk(writes == 0, "R4 no write commands when already set", writes, 0);

        // Case C: write-enable ignored once
        run_case(8'h00, 1, 0, 150, 0);
        n = q_op.size();
        chk(done == 1'b1 && err == 1'b0, "R5 retry run outcome", {done, err}, 2'b10);
        chk(n >= 8, "R5 retry run count", n, 8);
        if (n >= 8) begin
            chk(q_op[1] == 6 && q_op[2] == 5 && q_ret[2][1] == 1'b0, "R5 latch not set first time", q_ret[2], 0);
            chk(q_op[3] == 6 && q_op[4] == 5 && q_ret[4][1] == 1'b1, "R5 latch set on retry", q_ret[4], 2);
            chk(q_op[5] == 1 && q_dat[5] == 'h40, "R6 write data from clear status", q_dat[5], 'h40);
        end

        // Case D: write never finishes
        run_case(8'h00, 0, 0, 1000000, 0);
        n = q_op.size();
        chk(err == 1'b1 && done == 1'b0, "R7 stuck busy gives error", {done, err}, 2'b01);
        chk(n == 4 + PLIM, "R7 poll budget", n, 4 + PLIM);
        if (n >= 1) chk(q_op[n-1] == 5 && (q_ret[n-1] & 1) == 1, "R7 last read still busy", q_ret[n-1], 3);
        repeat (40) @(negedge clk);
        chk(err == 1'b1 && cs_n == 1'b1 && q_op.size() == n, "R9 error held, no more commands", q_op.size(), n);

        // Case E: quad-enable does not stick
        run_case(8'h00, 0, 1, 100, 0);
        n = q_op.size();
        chk(err == 1'b1 && done == 1'b0, "R8 verify failure gives error", {done, err}, 2'b01);
        if (n >= 1) chk(q_op[n-1] == 5 && q_ret[n-1][6] == 1'b0, "R8 verify read shows bit 6 clear", q_ret[n-1], 0);

        // Case F: write-enable never takes
        run_case(8'h00, 99, 0, 100, 0);
        n = q_op.size();
        chk(err == 1'b1 && done == 1'b0, "R5 retry exhaustion gives error", {done, err}, 2'b01);
        chk(n == 1 + 2 * TRIES, "R5 retry count", n, 1 + 2 * TRIES);
        writes = 0;
        foreach (q_op[i]) if (q_op[i] == 1) writes++;
        chk(writes == 0, "R5 no status write without latch", writes, 0);

        // Case G: restart after error reaches done
        run_case(8'h3C, 0, 0, 120, 0);
        chk(done == 1'b1 && err == 1'b0, "R9 new start clears error", {done, err}, 2'b10);
        n = q_op.size();
        if (n >= 4) chk(q_dat[3] == 'h7C, "R6 protect bits preserved", q_dat[3], 'h7C);

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

endmodule